// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block keeps the frame clock of a full-speed USB host controller. A 14-bit down counter counts bit times through each frame. It starts from a programmable frame length and steps down once per bit-time tick. When it reaches zero, the next tick reloads it with the programmed length, emits a one-cycle start-of-frame strobe, and copies a software-owned toggle bit into the frame toggle flag. Software can tell from that flag which length setting the current frame uses.

The remaining count is compared against two thresholds. These give the schedulers two qualifiers. The first is a window in which periodic list processing may begin. The second is a decision on whether a short low-speed packet can still be committed before the frame ends. The block also passes the programmed largest full-speed packet size through to the scheduler. Software reaches the block through a simple register write port and a combinational read port.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining count is 0, the frame toggle is 0, the start-of-frame strobe is low, and the length register (select 0) reads back its reset value. In that register, bits 13:0 hold the frame length, bits 30:16 hold the largest packet size and bit 31 holds the length toggle.
- R2: While `run` is low, bit ticks leave the remaining count unchanged and no start-of-frame strobe is issued.
- R3: While `run` is high, each bit tick with a non-zero count lowers the count by exactly one. Cycles without a tick leave it unchanged.
- R4: A bit tick that arrives with the count at zero reloads the count from the frame length. In the cycle after that tick, `sof_pulse` is high for one cycle.
- R5: On each reload the frame toggle output takes the value of the length toggle bit (select 0, bit 31).
- R6: Writing the length register does not change the running count. The new length is used at the next reload.
- R7: `periodic_window` is high exactly when the remaining count is at or below the periodic-start value (select 2, bits 13:0).
- R8: `ls_commit` is high exactly when the remaining count is strictly above the low-speed threshold (select 3, bits 10:0).
- R9: `max_pkt` presents the largest-packet field last written to select 0, bits 30:16, and the same field reads back.
- R10: Select 1 reads the remaining count in bits 13:0 and the frame toggle in bit 31. Writes to select 1 are ignored. Selects 4 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables frame counting |
| bit_tick | input | 1 | One-cycle pulse per full-speed bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| remaining | output | 14 | Bit times left in the current frame |
| frame_toggle | output | 1 | Toggle captured at the last reload |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| periodic_window | output | 1 | Periodic processing may start |
| ls_commit | output | 1 | Low-speed packet may still be committed |
| max_pkt | output | 15 | Largest full-speed packet size |

## Verification
The embedded properties check the counter on every cycle. They cover holding while idle, single steps on ticks, the reload together with its strobe, and the capture of the toggle. They also check that the length register changes only when it is written. Only the bench scenarios can show the threshold boundaries, where the count equals a threshold or sits one away from it. The same holds for the deferred effect of a mid-frame length change, the register read map, and the fact that writes to the remaining-count register have no effect.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;
  localparam int CNT_W  = 14;
  localparam int PKT_W  = 15;
  localparam int LS_W   = 11;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;
  localparam int PKT_LSB = 16;
  localparam int TGL_BIT = DATA_W - 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_LENGTH = 3'd0,
    SEL_REMAIN = 3'd1,
    SEL_PSTART = 3'd2,
    SEL_LSTH   = 3'd3
  } reg_sel_e;

  function automatic logic [CNT_W-1:0] f_next_count(
    input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] len);
    return (cur == '0) ? len : cur - CNT_W'(1);
  endfunction

  function automatic logic f_in_window(
    input logic [CNT_W-1:0] rem, input logic [CNT_W-1:0] start);
    return rem <= start;
  endfunction

  function automatic logic f_ls_ok(
    input logic [CNT_W-1:0] rem, input logic [LS_W-1:0] th);
    return rem > CNT_W'(th);
  endfunction
endpackage

// File: rtl/fmt_regs.sv
module fmt_regs
  import usb_frame_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_LENGTH = 14'd11999,
  parameter logic [PKT_W-1:0] RST_MAXPKT = 15'd10104,
  parameter logic [CNT_W-1:0] RST_PSTART = '0,
  parameter logic [LS_W-1:0]  RST_LSTH   = 11'h628
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  remain,
  input  logic              frt,
  output logic [CNT_W-1:0]  length,
  output logic              length_tgl,
  output logic [PKT_W-1:0]  max_pkt,
  output logic [CNT_W-1:0]  pstart,
  output logic [LS_W-1:0]   lsth
);
  logic wr_length, wr_pstart, wr_lsth;
  assign wr_length = wr_en && (wr_sel == SEL_LENGTH);
  assign wr_pstart = wr_en && (wr_sel == SEL_PSTART);
  assign wr_lsth   = wr_en && (wr_sel == SEL_LSTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      length     <= RST_LENGTH;
      length_tgl <= 1'b0;
      max_pkt    <= RST_MAXPKT;
      pstart     <= RST_PSTART;
      lsth       <= RST_LSTH;
    end else begin
      if (wr_length) begin
        length     <= wr_data[CNT_W-1:0];
        max_pkt    <= wr_data[PKT_LSB +: PKT_W];
        length_tgl <= wr_data[TGL_BIT];
      end
      if (wr_pstart) pstart <= wr_data[CNT_W-1:0];
      if (wr_lsth)   lsth   <= wr_data[LS_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_LENGTH: begin
        rd_data[CNT_W-1:0]         = length;
        rd_data[PKT_LSB +: PKT_W]  = max_pkt;
        rd_data[TGL_BIT]           = length_tgl;
      end
      SEL_REMAIN: begin
        rd_data[CNT_W-1:0] = remain;
        rd_data[TGL_BIT]   = frt;
      end
      SEL_PSTART: rd_data[CNT_W-1:0] = pstart;
      SEL_LSTH:   rd_data[LS_W-1:0]  = lsth;
      default:    rd_data = '0;
    endcase
  end

  // R6: the frame length changes only on a write to its own select
  p_length_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_LENGTH) |=> $stable(length));
  // R10: the periodic start value changes only on its own write
  p_pstart_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_PSTART) |=> $stable(pstart));
endmodule

// File: rtl/fmt_down_counter.sv
module fmt_down_counter
  import usb_frame_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] length,
  input  logic             length_tgl,
  output logic [CNT_W-1:0] count,
  output logic             frt,
  output logic             sof
);
  logic advance, wrap;
  assign advance = run && tick;
  assign wrap    = advance && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      frt   <= 1'b0;
      sof   <= 1'b0;
    end else begin
      sof <= wrap;
      if (advance) count <= f_next_count(count, length);
      if (wrap)    frt   <= length_tgl;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count) && !sof);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count != '0) |=> (count == CNT_W'($past(count) - CNT_W'(1))));
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == '0) |=> (sof && count == $past(length)));
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count == '0) |=> (frt == $past(length_tgl)));
  p_frt_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |-> $stable(frt));
endmodule

// File: rtl/fmt_qualifier.sv
module fmt_qualifier
  import usb_frame_timer_pkg::*;
(
  input  logic [CNT_W-1:0] remain,
  input  logic [CNT_W-1:0] pstart,
  input  logic [LS_W-1:0]  lsth,
  output logic             periodic_window,
  output logic             ls_commit
);
  always_comb begin
    periodic_window = f_in_window(remain, pstart);
    ls_commit       = f_ls_ok(remain, lsth);
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frame_timer_pkg::*;
#(
  parameter logic [13:0] RST_LENGTH = 14'd11999,
  parameter logic [14:0] RST_MAXPKT = 15'd10104,
  parameter logic [13:0] RST_PSTART = 14'd0,
  parameter logic [10:0] RST_LSTH   = 11'h628
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        bit_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic [13:0] remaining,
  output logic        frame_toggle,
  output logic        sof_pulse,
  output logic        periodic_window,
  output logic        ls_commit,
  output logic [14:0] max_pkt
);
  logic [CNT_W-1:0] length_w, pstart_w;
  logic [LS_W-1:0]  lsth_w;
  logic             length_tgl_w;

  fmt_regs #(
    .RST_LENGTH(RST_LENGTH), .RST_MAXPKT(RST_MAXPKT),
    .RST_PSTART(RST_PSTART), .RST_LSTH(RST_LSTH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .remain(remaining), .frt(frame_toggle), .length(length_w),
    .length_tgl(length_tgl_w), .max_pkt(max_pkt),
    .pstart(pstart_w), .lsth(lsth_w)
  );

  fmt_down_counter u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(bit_tick),
    .length(length_w), .length_tgl(length_tgl_w),
    .count(remaining), .frt(frame_toggle), .sof(sof_pulse)
  );

  fmt_qualifier u_qual (
    .remain(remaining), .pstart(pstart_w), .lsth(lsth_w),
    .periodic_window(periodic_window), .ls_commit(ls_commit)
  );

  // R7/R8: both qualifiers may only move when the count or a threshold moved
  p_qual_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(remaining) && $past(!wr_en)) |-> ($stable(periodic_window) && $stable(ls_commit)));
endmodule

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  logic clk = 0, rst_n = 0, run = 0, bit_tick = 0, wr_en = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [13:0] remaining;
  logic frame_toggle, sof_pulse, periodic_window, ls_commit;
  logic [14:0] max_pkt;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_frame_timer u_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .remaining(remaining), .frame_toggle(frame_toggle), .sof_pulse(sof_pulse),
    .periodic_window(periodic_window), .ls_commit(ls_commit), .max_pkt(max_pkt));

  localparam int NV = 6;
  localparam logic [13:0] V_LEN [NV] = '{14'd100, 14'd100, 14'd100, 14'd100, 14'd1000, 14'd16383};
  localparam logic [13:0] V_PS  [NV] = '{14'd40, 14'd40, 14'd40, 14'd40, 14'd999, 14'd16383};
  localparam logic [10:0] V_LS  [NV] = '{11'd20, 11'd20, 11'd20, 11'd20, 11'd1000, 11'd2047};
  localparam int          V_N   [NV] = '{60, 59, 80, 79, 0, 0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; run = 0; bit_tick = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    rd_sel = sel; #1 d = rd_data;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        finish_up();
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic [13:0] c;
    do_reset();
    // R1: reset state
    check("R1 remaining", 32'(remaining), 0);
    check("R1 toggle", 32'(frame_toggle), 0);
    check("R1 sof", 32'(sof_pulse), 0);
    rd(3'd0, d);
    check("R1 length reg", d, {1'b0, 15'd10104, 2'b00, 14'd11999});
    // R2: ticks ignored while stopped
    repeat (3) begin
      tick();
      check("R2 sof", 32'(sof_pulse), 0);
    end
    check("R2 remaining", 32'(remaining), 0);
    // R4/R5: reload with toggle set
    wr(3'd0, {1'b1, 15'd64, 2'b00, 14'd5});
    run = 1;
    tick();
    check("R4 reload", 32'(remaining), 5);
    check("R4 sof", 32'(sof_pulse), 1);
    check("R5 toggle", 32'(frame_toggle), 1);
    @(negedge clk);
    check("R4 sof width", 32'(sof_pulse), 0);
    // R3: hold without tick, step with tick
    repeat (3) @(negedge clk);
    check("R3 hold", 32'(remaining), 5);
    tick();
    check("R3 step", 32'(remaining), 4);
    tick();
    // R6: mid-frame length write
    wr(3'd0, {1'b0, 15'd64, 2'b00, 14'd9});
    check("R6 undisturbed", 32'(remaining), 3);
    repeat (3) tick();
    check("R3 zero", 32'(remaining), 0);
    check("R4 no early sof", 32'(sof_pulse), 0);
    tick();
    check("R6 new length", 32'(remaining), 9);
    check("R4 sof again", 32'(sof_pulse), 1);
    check("R5 toggle cleared", 32'(frame_toggle), 0);
    // R9: largest packet field
    wr(3'd0, {1'b1, 15'h1234, 2'b00, 14'd9});
    check("R9 output", 32'(max_pkt), 32'h1234);
    rd(3'd0, d);
    check("R9 readback", 32'(d[30:16]), 32'h1234);
    // R10: remaining read, write ignored, unused selects zero
    wr(3'd1, 32'hFFFF_FFFF);
    check("R10 write ignored", 32'(remaining), 9);
    rd(3'd1, d);
    check("R10 remain read", d, {1'b0, 17'd0, 14'd9});
    rd(3'd5, d);
    check("R10 unused sel", d, 0);
    // R2 again: stopped mid-frame
    run = 0;
    tick(); tick();
    check("R2 mid-frame hold", 32'(remaining), 9);
    // R7/R8: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(3'd2, 32'(V_PS[i]));
      wr(3'd3, 32'(V_LS[i]));
      wr(3'd0, {18'd0, V_LEN[i]});
      run = 1;
      tick();
      for (int k = 0; k < V_N[i]; k++) tick();
      c = V_LEN[i] - 14'(V_N[i]);
      check("R3 vector count", 32'(remaining), 32'(c));
      check("R7 window", 32'(periodic_window), 32'(c <= V_PS[i]));
      check("R8 ls commit", 32'(ls_commit), 32'(c > {3'd0, V_LS[i]}));
    end
    finish_up();
  end
endmodule